// File: doc/BRIEF.md
# CPU Low-Power Mode Sequencer

This block steps one core through a low-power episode and back to running. The core's wait-for-interrupt reaches the block as a one-cycle pulse. At that pulse the block gates the core clock and runs the sequence for the mode held in a small mode register. There are four modes. Standby is clock gating plus an optional cache-standby request. Retention lowers the supply to a level that keeps state. Standalone power-down removes the core's supply on its own. Full collapse adds a shutdown handshake with the system resource manager when every core is idle. A wake interrupt starts the exit path. That path undoes the entry steps in reverse order. The core is released only once the cache and the system report ready.

The block owns the timing of the outputs that gate the clock, select the retention voltage, open the power switch and hold the core in reset. Power restore is followed by a settle delay. The core reset is then held for a fixed count, so that the core warm-boots. Every wait for an acknowledge has a cycle limit. If the limit expires, a sticky error flag is set and the exit continues. After any deeper mode, the mode register returns to standby.

Top module: `lpm_seq`

## Requirements
- R1: After reset, every control output is low, `err_flag` is 0, `prog_mode` reads 0 (standby) and `st_state` reads 0 with `st_asleep` low.
- R2: A `wfi` pulse in the active state asserts `core_clk_gate` from the next cycle. The gate stays high until the cycle in which `st_asleep` falls, and both fall together.
- R3: Mode 0 (standby): `cache_stby_req` rises only when `all_idle` is high. On wake, the request drops and the core is released once `cache_stby_ack` is low. With no request, release happens on the first edge after wake.
- R4: Mode 1 (retention): `ret_volt_sel` is high while asleep. On wake it drops, and the core is released SETTLE_CYC cycles later.
- R5: Mode 2 (standalone power-down): `core_rst` rises first and `pwr_off` rises one cycle later, with no resource-manager request. On wake, `pwr_off` drops, the settle delay runs, cache readiness (ack low) is confirmed, and `core_rst` is held RST_HOLD_CYC more cycles. `core_rst` never falls while `pwr_off` is high.
- R6: Mode 3 (full collapse): this is mode 2 plus, if `all_idle` is high once power is off, `rm_req` raised and held until wake. The exit drops `rm_req` and waits for `rm_ack` low before power restore. With `all_idle` low, mode 3 behaves like mode 2.
- R7: When a non-standby sequence completes, `prog_mode` reads 0 in the release cycle, unless it is written in that same cycle.
- R8: An acknowledge wait that exceeds ACK_TMO_CYC cycles sets `err_flag`, which stays set until reset. The sequence then moves on to its exit steps. A stuck resource-manager ack ends the episode without any wake.
- R9: A wake seen in the cycle after a mode 2 or 3 entry, before power is removed, skips the power steps. `pwr_off` never rises, and the core is released after the reset hold.
- R10: `wake_irq` in the active state has no effect: `st_asleep` and `core_clk_gate` stay low.
- R11: `st_state` is 0 exactly when `st_asleep` is low. `prog_mode` returns the last value written through `mode_wr`/`mode_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode to program: 0 standby, 1 retention, 2 standalone power-down, 3 full collapse |
| wfi | input | 1 | One-cycle wait-for-interrupt trigger from the core |
| wake_irq | input | 1 | Wake interrupt |
| all_idle | input | 1 | All cores idle |
| cache_stby_ack | input | 1 | Cache hierarchy in standby (low means ready) |
| rm_ack | input | 1 | Resource manager shutdown acknowledge |
| core_clk_gate | output | 1 | Core clock gate enable |
| ret_volt_sel | output | 1 | Select retention supply level |
| pwr_off | output | 1 | Core power switch open |
| core_rst | output | 1 | Core reset |
| cache_stby_req | output | 1 | Cache standby request |
| rm_req | output | 1 | Subsystem shutdown request to resource manager |
| err_flag | output | 1 | Sticky acknowledge-timeout flag |
| prog_mode | output | 2 | Programmed mode readback |
| st_state | output | 4 | Sequencer state code, 0 = active |
| st_asleep | output | 1 | Core is in a low-power episode |

## Verification
The bench builds the block with SETTLE_CYC=3, RST_HOLD_CYC=2 and ACK_TMO_CYC=5. Each exit latency is then a small number that can be predicted exactly: 1, 3, 4, 7 and 9 cycles across the modes. The short timeout lets both acknowledge-timeout paths (cache exit and resource-manager entry) expire within a few cycles. The one-cycle window for an entry abort is hit directly by raising wake right after the trigger.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        M_STBY = 2'd0,
        M_RET  = 2'd1,
        M_SPD  = 2'd2,
        M_COL  = 2'd3
    } lpm_mode_e;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_SBY_WAIT = 4'd1,
        S_SBY_CACH = 4'd2,
        S_CACH_EXT = 4'd3,
        S_RET_SLP  = 4'd4,
        S_RET_UP   = 4'd5,
        S_PD_RST   = 4'd6,
        S_PD_OFF   = 4'd7,
        S_PC_RM    = 4'd8,
        S_PD_SLP   = 4'd9,
        S_RM_EXT   = 4'd10,
        S_PWR_ON   = 4'd11,
        S_RDY      = 4'd12,
        S_RST_HOLD = 4'd13
    } lpm_state_e;

endpackage

// File: rtl/lpm_timer.sv
module lpm_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // Countdown paces the settle, hold and timeout windows (R4, R5, R8)
    p_tmr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic [1:0] wdata,
    input  logic      done,
    output lpm_mode_e mode
);

    lpm_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr)
            mode_d = lpm_mode_e'(wdata);
        else if (done)
            mode_d = M_STBY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_STBY;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    p_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr) |=> (mode_q == M_STBY));

    p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mode_q == lpm_mode_e'($past(wdata))));

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int SETTLE_CYC   = 8,
    parameter int RST_HOLD_CYC = 4,
    parameter int ACK_TMO_CYC  = 16,
    parameter int CW           = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wfi,
    input  logic          wake,
    input  logic          all_idle,
    input  logic          cache_ack,
    input  logic          rm_ack,
    input  lpm_mode_e     prog_mode,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          done,
    output logic          clk_gate,
    output logic          ret_volt,
    output logic          pwr_off,
    output logic          core_rst,
    output logic          cache_req,
    output logic          rm_req,
    output logic          err,
    output lpm_state_e    state
);

    localparam logic [CW-1:0] V_SETTLE = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] V_HOLD   = CW'(RST_HOLD_CYC - 1);
    localparam logic [CW-1:0] V_TMO    = CW'(ACK_TMO_CYC - 1);

    typedef struct packed {
        lpm_state_e st;
        lpm_mode_e  run_mode;
        logic       clk_gate;
        logic       ret_volt;
        logic       pwr_off;
        logic       core_rst;
        logic       cache_req;
        logic       rm_req;
        logic       err;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        done     = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (wfi) begin
                    d.clk_gate = 1'b1;
                    d.run_mode = prog_mode;
                    unique case (prog_mode)
                        M_STBY: d.st = S_SBY_WAIT;
                        M_RET: begin
                            d.st       = S_RET_SLP;
                            d.ret_volt = 1'b1;
                        end
                        default: begin
                            d.st       = S_PD_RST;
                            d.core_rst = 1'b1;
                        end
                    endcase
                end
            end
            S_SBY_WAIT: begin
                if (wake) begin
                    d.st       = S_IDLE;
                    d.clk_gate = 1'b0;
                    done       = 1'b1;
                end else if (all_idle) begin
                    d.st        = S_SBY_CACH;
                    d.cache_req = 1'b1;
                end
            end
            S_SBY_CACH: begin
                if (wake) begin
                    d.st        = S_CACH_EXT;
                    d.cache_req = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = V_TMO;
                end
            end
            S_CACH_EXT: begin
                if (!cache_ack || tmr_zero) begin
                    if (cache_ack) d.err = 1'b1;
                    d.st       = S_IDLE;
                    d.clk_gate = 1'b0;
                    done       = 1'b1;
                end
            end
            S_RET_SLP: begin
                if (wake) begin
                    d.st       = S_RET_UP;
                    d.ret_volt = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = V_SETTLE;
                end
            end
            S_RET_UP: begin
                if (tmr_zero) begin
                    d.st       = S_IDLE;
                    d.clk_gate = 1'b0;
                    done       = 1'b1;
                end
            end
            S_PD_RST: begin
                if (wake) begin
                    d.st     = S_RST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = V_HOLD;
                end else begin
                    d.st      = S_PD_OFF;
                    d.pwr_off = 1'b1;
                end
            end
            S_PD_OFF: begin
                if (wake) begin
                    d.st      = S_PWR_ON;
                    d.pwr_off = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = V_SETTLE;
                end else if (q.run_mode == M_COL && all_idle) begin
                    d.st     = S_PC_RM;
                    d.rm_req = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = V_TMO;
                end else begin
                    d.st = S_PD_SLP;
                end
            end
            S_PC_RM: begin
                if (wake || (tmr_zero && !rm_ack)) begin
                    if (!wake) d.err = 1'b1;
                    d.st     = S_RM_EXT;
                    d.rm_req = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = V_TMO;
                end else if (rm_ack) begin
                    d.st = S_PD_SLP;
                end
            end
            S_PD_SLP: begin
                if (wake) begin
                    if (q.rm_req) begin
                        d.st     = S_RM_EXT;
                        d.rm_req = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = V_TMO;
                    end else begin
                        d.st      = S_PWR_ON;
                        d.pwr_off = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = V_SETTLE;
                    end
                end
            end
            S_RM_EXT: begin
                if (!rm_ack || tmr_zero) begin
                    if (rm_ack) d.err = 1'b1;
                    d.st      = S_PWR_ON;
                    d.pwr_off = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = V_SETTLE;
                end
            end
            S_PWR_ON: begin
                if (tmr_zero) begin
                    d.st     = S_RDY;
                    tmr_load = 1'b1;
                    tmr_val  = V_TMO;
                end
            end
            S_RDY: begin
                if (!cache_ack || tmr_zero) begin
                    if (cache_ack) d.err = 1'b1;
                    d.st     = S_RST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = V_HOLD;
                end
            end
            S_RST_HOLD: begin
                if (tmr_zero) begin
                    d.st       = S_IDLE;
                    d.core_rst = 1'b0;
                    d.clk_gate = 1'b0;
                    done       = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, run_mode: M_STBY, default: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign clk_gate  = q.clk_gate;
    assign ret_volt  = q.ret_volt;
    assign pwr_off   = q.pwr_off;
    assign core_rst  = q.core_rst;
    assign cache_req = q.cache_req;
    assign rm_req    = q.rm_req;
    assign err       = q.err;
    assign state     = q.st;

    p_gate_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pwr_off || q.ret_volt || q.cache_req) |-> q.clk_gate);

    p_off_in_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.pwr_off |-> q.core_rst);

    p_rst_after_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.core_rst) |-> !q.pwr_off && !$past(q.pwr_off));

    p_rm_only_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.rm_req |-> (q.run_mode == M_COL && q.pwr_off));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err);

    p_idle_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && !wfi) |=> (q.st == S_IDLE && !q.clk_gate));

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int SETTLE_CYC   = 8,
    parameter int RST_HOLD_CYC = 4,
    parameter int ACK_TMO_CYC  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       wfi,
    input  logic       wake_irq,
    input  logic       all_idle,
    input  logic       cache_stby_ack,
    input  logic       rm_ack,
    output logic       core_clk_gate,
    output logic       ret_volt_sel,
    output logic       pwr_off,
    output logic       core_rst,
    output logic       cache_stby_req,
    output logic       rm_req,
    output logic       err_flag,
    output logic [1:0] prog_mode,
    output logic [3:0] st_state,
    output logic       st_asleep
);

    localparam int MAX_A = (SETTLE_CYC > RST_HOLD_CYC) ? SETTLE_CYC : RST_HOLD_CYC;
    localparam int MAX_C = (MAX_A > ACK_TMO_CYC) ? MAX_A : ACK_TMO_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    lpm_mode_e     mode;
    lpm_state_e    state;
    logic          done;
    logic          tmr_load;
    logic          tmr_zero;
    logic [CW-1:0] tmr_val;

    lpm_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .done  (done),
        .mode  (mode)
    );

    lpm_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    lpm_fsm #(
        .SETTLE_CYC   (SETTLE_CYC),
        .RST_HOLD_CYC (RST_HOLD_CYC),
        .ACK_TMO_CYC  (ACK_TMO_CYC),
        .CW           (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi       (wfi),
        .wake      (wake_irq),
        .all_idle  (all_idle),
        .cache_ack (cache_stby_ack),
        .rm_ack    (rm_ack),
        .prog_mode (mode),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .done      (done),
        .clk_gate  (core_clk_gate),
        .ret_volt  (ret_volt_sel),
        .pwr_off   (pwr_off),
        .core_rst  (core_rst),
        .cache_req (cache_stby_req),
        .rm_req    (rm_req),
        .err       (err_flag),
        .state     (state)
    );

    assign prog_mode = mode;
    assign st_state  = state;
    assign st_asleep = (state != S_IDLE);

    p_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_asleep == core_clk_gate);

endmodule

// File: tb/lpm_seq_test.sv
module lpm_seq_test;

    localparam int S = 3;
    localparam int R = 2;
    localparam int T = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'd0;
    logic wfi = 1'b0, wake_irq = 1'b0, all_idle = 1'b0;
    logic cache_stby_ack = 1'b0, rm_ack = 1'b0;
    logic core_clk_gate, ret_volt_sel, pwr_off, core_rst, cache_stby_req, rm_req, err_flag;
    logic [1:0] prog_mode;
    logic [3:0] st_state;
    logic st_asleep;

    bit cache_stuck = 1'b0;
    bit rm_dead = 1'b0;
    bit done_run = 1'b0;
    int n_checks = 0;
    int n_errs = 0;

    typedef struct {
        int       lat;
        bit       err;
        bit [3:0] seen;
        string    tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    lpm_seq #(.SETTLE_CYC(S), .RST_HOLD_CYC(R), .ACK_TMO_CYC(T)) uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .wfi(wfi), .wake_irq(wake_irq), .all_idle(all_idle),
        .cache_stby_ack(cache_stby_ack), .rm_ack(rm_ack),
        .core_clk_gate(core_clk_gate), .ret_volt_sel(ret_volt_sel), .pwr_off(pwr_off),
        .core_rst(core_rst), .cache_stby_req(cache_stby_req), .rm_req(rm_req),
        .err_flag(err_flag), .prog_mode(prog_mode), .st_state(st_state), .st_asleep(st_asleep)
    );

    // acknowledge models: one cycle behind the request
    always @(posedge clk) begin
        cache_stby_ack <= cache_stuck ? 1'b1 : cache_stby_req;
        rm_ack         <= rm_dead ? 1'b0 : rm_req;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: gathers one episode and compares at release
    bit in_seq = 1'b0;
    int lat = -1;
    bit [3:0] seen;
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            if (st_asleep && !in_seq) begin
                in_seq = 1'b1;
                seen   = '0;
                lat    = -1;
            end
            if (in_seq && st_asleep) begin
                seen |= {rm_req, pwr_off, ret_volt_sel, cache_stby_req};
                if (lat >= 0) lat++;
                else if (wake_irq) lat = 0;
            end else if (in_seq) begin
                exp_t e;
                if (lat >= 0) lat++;
                in_seq = 1'b0;
                if (sb_q.size() == 0) begin
                    chk("R11 unexpected episode", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk({e.tag, " exit latency"}, lat, e.lat);
                    chk({e.tag, " outputs seen {rm,off,ret,cache}"}, int'(seen), int'(e.seen));
                    chk({e.tag, " R8 err_flag"}, int'(err_flag), int'(e.err));
                    chk({e.tag, " R7 mode back to standby"}, int'(prog_mode), 0);
                    chk({e.tag, " R2 clock ungated at release"}, int'(core_clk_gate), 0);
                    chk({e.tag, " R5 reset released"}, int'(core_rst), 0);
                    chk({e.tag, " R11 state code active"}, int'(st_state), 0);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input logic [1:0] m, input bit idle, input int wdly,
                       input int elat, input bit eerr, input bit [3:0] eseen,
                       input string tag);
        exp_t e;
        e.lat = elat; e.err = eerr; e.seen = eseen; e.tag = tag;
        sb_q.push_back(e);
        mode_wr = 1'b1; mode_wdata = m;
        tick();
        mode_wr = 1'b0;
        all_idle = idle;
        wfi = 1'b1;
        tick();
        wfi = 1'b0;
        if (wdly >= 0) begin
            repeat (wdly) tick();
            wake_irq = 1'b1;
        end
        for (int i = 0; i < 200 && st_asleep; i++) tick();
        tick();
        wake_irq = 1'b0;
        all_idle = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 core_clk_gate", int'(core_clk_gate), 0);
        chk("R1 outputs", int'({ret_volt_sel, pwr_off, core_rst, cache_stby_req, rm_req}), 0);
        chk("R1 err_flag", int'(err_flag), 0);
        chk("R1 prog_mode", int'(prog_mode), 0);
        chk("R1 st_state", int'(st_state), 0);
        rst_n = 1'b1;
        repeat (2) tick();
        // R10 wake in active state
        wake_irq = 1'b1;
        repeat (3) tick();
        chk("R10 asleep stays low", int'(st_asleep), 0);
        chk("R10 gate stays low", int'(core_clk_gate), 0);
        wake_irq = 1'b0;
        tick();
        // R11 mode readback
        mode_wr = 1'b1; mode_wdata = 2'd2;
        tick();
        mode_wr = 1'b0;
        chk("R11 prog_mode readback", int'(prog_mode), 2);
        mode_wr = 1'b1; mode_wdata = 2'd0;
        tick();
        mode_wr = 1'b0;
        // R2 gate asserted after trigger
        all_idle = 1'b0;
        wfi = 1'b1;
        tick();
        wfi = 1'b0;
        chk("R2 clock gated after wfi", int'(core_clk_gate), 1);
        chk("R11 asleep after wfi", int'(st_asleep), 1);
        sb_q.push_back('{lat: 1, err: 1'b0, seen: 4'b0000, tag: "R2 plain standby"});
        repeat (2) tick();
        wake_irq = 1'b1;
        tick(); tick();
        wake_irq = 1'b0;
        repeat (3) tick();

        run(2'd0, 1'b0, 4, 1, 1'b0, 4'b0000, "R3 standby not all idle");
        run(2'd0, 1'b1, 4, 3, 1'b0, 4'b0001, "R3 standby with cache");
        run(2'd1, 1'b0, 4, 1 + S, 1'b0, 4'b0010, "R4 retention");
        run(2'd2, 1'b1, 5, 2 + S + R, 1'b0, 4'b0100, "R5 standalone power-down");
        run(2'd3, 1'b1, 8, 4 + S + R, 1'b0, 4'b1100, "R6 collapse with handshake");
        run(2'd3, 1'b0, 5, 2 + S + R, 1'b0, 4'b0100, "R6 collapse not all idle");
        run(2'd2, 1'b0, 0, 1 + R, 1'b0, 4'b0000, "R9 entry abort");
        rm_dead = 1'b1;
        run(2'd3, 1'b1, -1, -1, 1'b1, 4'b1100, "R8 rm ack timeout");
        rm_dead = 1'b0;
        cache_stuck = 1'b1;
        run(2'd0, 1'b1, 4, 1 + T, 1'b1, 4'b0001, "R8 cache exit timeout");
        cache_stuck = 1'b0;
        repeat (2) tick();
        chk("R8 err_flag sticky", int'(err_flag), 1);
        chk("R11 scoreboard drained", sb_q.size(), 0);
        done_run = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            done_run = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule